// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken by running two component predictors side by side and letting a choice table decide which one to trust. The first component follows each branch's own past. A table of per-branch outcome histories is indexed by fetch-address bits. The selected history then indexes a shared table of 3-bit saturating counters. The second component follows the path the program took. A register holding the most recent outcomes of all branches indexes a table of 2-bit saturating counters. The same global history also indexes the table of 2-bit choice counters.

The prediction side is purely combinational. A fetch address goes in, and the final direction and both component directions come out in the same cycle. The update side is applied at the clock edge. It takes the branch address, the resolved outcome and the two component directions captured at fetch time. It then trains the counters, shifts the outcome into both histories, and moves the choice counter when the components disagreed. A context-switch input returns every table and history to its start state, exactly as reset does.

Top module: `tournament_predictor`

## Requirements
- R1: After synchronous active-low reset, every 3-bit counter holds 3, every 2-bit counter (direction and choice) holds 1, and every history is zero, so all three prediction outputs read 0 for any address.
- R2: The per-branch history table has 1024 entries of 10 bits, selected by address bits [11:2]; addresses equal in those bits share one history, and each update shifts the outcome into bit 0 of the selected entry.
- R3: The local counter table holds 1024 3-bit counters indexed by the selected 10-bit history; the counter's top bit is the local direction; an update moves it one step toward the outcome, saturating at 0 and 7.
- R4: The global history is 12 bits; each update shifts the outcome into bit 0; it indexes 4096 2-bit counters whose top bit is the global direction; each update moves that counter one step toward the outcome, saturating at 0 and 3.
- R5: The choice table holds 4096 2-bit counters indexed by the global history; a value of 2 or 3 makes the final direction equal to the global direction, and 0 or 1 makes it equal to the local direction.
- R6: A choice counter changes only on an update whose supplied component directions differ; it then moves one step (saturating) toward the component whose direction equalled the outcome.
- R7: The context-switch input, sampled at a rising edge, restores the R1 state in all tables and histories and overrides an update presented in the same cycle.
- R8: Predictions reflect the state as of the last rising edge; an update presented together with a prediction request does not affect that request, and its effect is visible from the next edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctx_clear | input | 1 | Context switch: clear all tables and histories |
| pred_pc | input | 32 | Fetch address to predict |
| pred_taken | output | 1 | Final direction (1 = taken) |
| pred_local | output | 1 | Local component direction |
| pred_global | output | 1 | Global component direction |
| upd_valid | input | 1 | Apply a training update this cycle |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome (1 = taken) |
| upd_local | input | 1 | Local direction given at fetch time |
| upd_global | input | 1 | Global direction given at fetch time |

## Verification
All three predictions are due in the same cycle as the fetch address. The bench therefore drives the address at the falling edge and samples 1 ns later, before any rising edge can intervene. An update takes effect at the next rising edge. Its consequences are sampled 1 ns after that edge, so the pre-update and post-update views of the same cycle are checked apart. A clear or reset is likewise judged 1 ns after the edge on which it is sampled, against a reference model that is stepped once per edge.

// File: rtl/tp_pkg.sv
// Package: shared sizing constants and the prediction bundle for the
// tournament predictor. Assumes power-of-two table depths throughout.
package tp_pkg;

    localparam int unsigned PC_W_DEF    = 32;
    localparam int unsigned IDX_LSB_DEF = 2;   // instruction alignment
    localparam int unsigned LIDX_W_DEF  = 10;  // per-branch history table index
    localparam int unsigned LHIST_W_DEF = 10;  // per-branch history length
    localparam int unsigned LCNT_W_DEF  = 3;   // local counter width
    localparam int unsigned GHIST_W_DEF = 12;  // global history length
    localparam int unsigned GCNT_W_DEF  = 2;   // global and choice counter width

    typedef struct packed {
        logic final_dir;
        logic local_dir;
        logic global_dir;
    } dir_bundle_t;

endpackage

// File: rtl/tp_sat_table.sv
// Saturating counter table.
// - Asynchronous read of the top bit of one entry for prediction.
// - One read-modify-write port that steps an entry up or down by one,
//   clamping at 0 and at the maximum value.
// - Synchronous clear (reset or context switch) loads INIT everywhere.
// Assumes a single write per cycle and a power-of-two depth.
module tp_sat_table #(
    parameter int unsigned IDX_W = 10,
    parameter int unsigned CNT_W = 2,
    parameter int unsigned INIT  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_msb,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_up
);
    localparam int unsigned DEPTH = 1 << IDX_W;
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CINIT = CNT_W'(INIT);

    logic [CNT_W-1:0] cnt_mem [DEPTH];
    logic [CNT_W-1:0] cur_val;
    logic [CNT_W-1:0] nxt_val;

    // Prediction read: the top bit of the addressed counter.
    assign rd_msb  = cnt_mem[rd_idx][CNT_W-1];
    assign cur_val = cnt_mem[wr_idx];

    // Saturating step toward the requested direction.
    always_comb begin
        nxt_val = cur_val;
        if (wr_up && (cur_val != CMAX))
            nxt_val = cur_val + 1'b1;
        else if (!wr_up && (cur_val != '0))
            nxt_val = cur_val - 1'b1;
    end

    // Table storage: clear to INIT, else write the stepped value.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            for (int i = 0; i < DEPTH; i++)
                cnt_mem[i] <= CINIT;
        end else if (wr_en) begin
            cnt_mem[wr_idx] <= nxt_val;
        end
    end

    AST_SAT_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clear && wr_up && cur_val == CMAX) |=> (cnt_mem[$past(wr_idx)] == CMAX)); // R3
    AST_SAT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clear && !wr_up && cur_val == '0) |=> (cnt_mem[$past(wr_idx)] == '0)); // R4
    AST_CLEAR_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt_mem[$past(rd_idx)] == CINIT)); // R7

endmodule

// File: rtl/tp_hist_table.sv
// Per-branch outcome history table.
// - Asynchronous read of one history for prediction.
// - The update port exposes the stored history of the branch being
//   trained (it indexes the local counters) and shifts the resolved
//   outcome into bit 0 at the clock edge.
// - Synchronous clear zeroes every entry.
module tp_hist_table #(
    parameter int unsigned IDX_W  = 10,
    parameter int unsigned HIST_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [HIST_W-1:0] rd_hist,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_bit,
    output logic [HIST_W-1:0] wr_hist_old
);
    localparam int unsigned DEPTH = 1 << IDX_W;

    logic [HIST_W-1:0] hist_mem [DEPTH];

    assign rd_hist     = hist_mem[rd_idx];
    assign wr_hist_old = hist_mem[wr_idx];

    // History storage: zero on clear, else shift in the outcome.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            for (int i = 0; i < DEPTH; i++)
                hist_mem[i] <= '0;
        end else if (wr_en) begin
            hist_mem[wr_idx] <= {wr_hist_old[HIST_W-2:0], wr_bit};
        end
    end

    AST_HIST_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clear) |=> (hist_mem[$past(wr_idx)][0] == $past(wr_bit))); // R2
    AST_HIST_AGES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clear) |=> (hist_mem[$past(wr_idx)][HIST_W-1:1] == $past(wr_hist_old[HIST_W-2:0]))); // R2

endmodule

// File: rtl/tournament_predictor.sv
// Tournament branch direction predictor (top).
// Prediction: combinational from pred_pc and the current state.
// Update: at the rising edge when upd_valid is high. Trains the local
// counter selected by the branch's stored history, the global counter and
// (on disagreement) the choice counter selected by the global history,
// then shifts the outcome into both histories.
// Assumes updates arrive in program order (no speculative history repair).
module tournament_predictor #(
    parameter int unsigned PC_W    = tp_pkg::PC_W_DEF,
    parameter int unsigned IDX_LSB = tp_pkg::IDX_LSB_DEF,
    parameter int unsigned LIDX_W  = tp_pkg::LIDX_W_DEF,
    parameter int unsigned LHIST_W = tp_pkg::LHIST_W_DEF,
    parameter int unsigned LCNT_W  = tp_pkg::LCNT_W_DEF,
    parameter int unsigned GHIST_W = tp_pkg::GHIST_W_DEF,
    parameter int unsigned GCNT_W  = tp_pkg::GCNT_W_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ctx_clear,
    input  logic [PC_W-1:0] pred_pc,
    output logic            pred_taken,
    output logic            pred_local,
    output logic            pred_global,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    input  logic            upd_local,
    input  logic            upd_global
);
    import tp_pkg::*;

    localparam int unsigned LIDX_HI    = IDX_LSB + LIDX_W - 1;
    localparam int unsigned LCNT_INIT  = (1 << (LCNT_W - 1)) - 1; // weakly not taken
    localparam int unsigned GCNT_INIT  = (1 << (GCNT_W - 1)) - 1;

    logic [GHIST_W-1:0] ghist_q;
    logic [LIDX_W-1:0]  pred_lidx;
    logic [LIDX_W-1:0]  upd_lidx;
    logic [LHIST_W-1:0] pred_lhist;
    logic [LHIST_W-1:0] upd_lhist;
    logic               choose_global;
    logic               comp_disagree;
    dir_bundle_t        dirs;
    logic               unused_pc_bits;

    assign pred_lidx = pred_pc[LIDX_HI:IDX_LSB];
    assign upd_lidx  = upd_pc[LIDX_HI:IDX_LSB];
    assign unused_pc_bits = ^{pred_pc[PC_W-1:LIDX_HI+1], pred_pc[IDX_LSB-1:0],
                              upd_pc[PC_W-1:LIDX_HI+1],  upd_pc[IDX_LSB-1:0]};
    assign comp_disagree = upd_local ^ upd_global;

    // Per-branch histories, indexed by fetch-address bits.
    tp_hist_table #(.IDX_W(LIDX_W), .HIST_W(LHIST_W)) u_lhist (
        .clk(clk), .rst_n(rst_n), .clear(ctx_clear),
        .rd_idx(pred_lidx), .rd_hist(pred_lhist),
        .wr_en(upd_valid), .wr_idx(upd_lidx), .wr_bit(upd_taken),
        .wr_hist_old(upd_lhist)
    );

    // Shared local counters, indexed by the per-branch history.
    tp_sat_table #(.IDX_W(LHIST_W), .CNT_W(LCNT_W), .INIT(LCNT_INIT)) u_lcnt (
        .clk(clk), .rst_n(rst_n), .clear(ctx_clear),
        .rd_idx(pred_lhist), .rd_msb(dirs.local_dir),
        .wr_en(upd_valid), .wr_idx(upd_lhist), .wr_up(upd_taken)
    );

    // Global counters, indexed by the global history.
    tp_sat_table #(.IDX_W(GHIST_W), .CNT_W(GCNT_W), .INIT(GCNT_INIT)) u_gcnt (
        .clk(clk), .rst_n(rst_n), .clear(ctx_clear),
        .rd_idx(ghist_q), .rd_msb(dirs.global_dir),
        .wr_en(upd_valid), .wr_idx(ghist_q), .wr_up(upd_taken)
    );

    // Choice counters: count up when global was right, down when local was.
    tp_sat_table #(.IDX_W(GHIST_W), .CNT_W(GCNT_W), .INIT(GCNT_INIT)) u_choice (
        .clk(clk), .rst_n(rst_n), .clear(ctx_clear),
        .rd_idx(ghist_q), .rd_msb(choose_global),
        .wr_en(upd_valid && comp_disagree), .wr_idx(ghist_q),
        .wr_up(upd_global == upd_taken)
    );

    // Final selection between the two component directions.
    always_comb begin
        dirs.final_dir = choose_global ? dirs.global_dir : dirs.local_dir;
    end

    assign pred_taken  = dirs.final_dir;
    assign pred_local  = dirs.local_dir;
    assign pred_global = dirs.global_dir;

    // Global history register: clear, else shift in each resolved outcome.
    always_ff @(posedge clk) begin
        if (!rst_n || ctx_clear)
            ghist_q <= '0;
        else if (upd_valid)
            ghist_q <= {ghist_q[GHIST_W-2:0], upd_taken};
    end

    AST_GHIST_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_clear |=> (ghist_q == '0)); // R7
    AST_GHIST_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !ctx_clear) |=> (ghist_q[0] == $past(upd_taken))); // R4
    AST_GHIST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_valid && !ctx_clear) |=> $stable(ghist_q)); // R8
    AST_AGREE_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_local == pred_global) |-> (pred_taken == pred_local)); // R5

endmodule

// File: tb/tournament_predictor_test.sv
module tournament_predictor_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctx_clear = 1'b0;
    logic [31:0] pred_pc = '0;
    logic        pred_taken, pred_local, pred_global;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic        upd_local = 1'b0;
    logic        upd_global = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk; // 50 MHz

    tournament_predictor uut (
        .clk(clk), .rst_n(rst_n), .ctx_clear(ctx_clear),
        .pred_pc(pred_pc), .pred_taken(pred_taken),
        .pred_local(pred_local), .pred_global(pred_global),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .upd_local(upd_local), .upd_global(upd_global)
    );

    // Reference model built from the requirements.
    int          m_lh [1024];
    int          m_lc [1024];
    int          m_gc [4096];
    int          m_ch [4096];
    int          m_gh;

    task automatic m_clear();
        for (int i = 0; i < 1024; i++) begin m_lh[i] = 0; m_lc[i] = 3; end
        for (int i = 0; i < 4096; i++) begin m_gc[i] = 1; m_ch[i] = 1; end
        m_gh = 0;
    endtask

    function automatic int sat(int v, bit up, int mx);
        if (up) return (v < mx) ? v + 1 : v;
        return (v > 0) ? v - 1 : v;
    endfunction

    function automatic bit m_local(logic [31:0] pc);
        return m_lc[m_lh[pc[11:2]]] >= 4;
    endfunction
    function automatic bit m_global();
        return m_gc[m_gh] >= 2;
    endfunction
    function automatic bit m_final(logic [31:0] pc);
        return (m_ch[m_gh] >= 2) ? m_global() : m_local(pc);
    endfunction

    task automatic m_update(logic [31:0] pc, bit tk, bit ul, bit ug);
        int li, h;
        li = int'(pc[11:2]);
        h  = m_lh[li];
        m_lc[h] = sat(m_lc[h], tk, 7);
        m_gc[m_gh] = sat(m_gc[m_gh], tk, 3);
        if (ul != ug) m_ch[m_gh] = sat(m_ch[m_gh], ug == tk, 3);
        m_lh[li] = ((h << 1) | int'(tk)) & 10'h3FF;
        m_gh = ((m_gh << 1) | int'(tk)) & 12'hFFF;
    endtask

    task automatic chk(string req, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // Check all three outputs for pc against the model (no clock edge).
    task automatic probe(logic [31:0] pc, string rl, string rg, string rf);
        @(negedge clk);
        pred_pc = pc;
        #1;
        chk(rl, pred_local,  m_local(pc));
        chk(rg, pred_global, m_global());
        chk(rf, pred_taken,  m_final(pc));
    endtask

    // Predict pc, check, then train with the outcome at the next edge.
    task automatic step(logic [31:0] pc, bit tk, string rf);
        probe(pc, "R3", "R4", rf);
        upd_valid  = 1'b1;
        upd_pc     = pc;
        upd_taken  = tk;
        upd_local  = pred_local;
        upd_global = pred_global;
        @(posedge clk);
        m_update(pc, tk, upd_local, upd_global);
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    // {taken, pc}
    localparam logic [32:0] VEC [24] = '{
        {1'b1, 32'h0000_0100}, {1'b1, 32'h0000_0100}, {1'b0, 32'h0000_0104},
        {1'b1, 32'h0000_0100}, {1'b1, 32'h0000_1100}, {1'b0, 32'h0000_0104},
        {1'b1, 32'h0000_0100}, {1'b0, 32'h0000_0108}, {1'b1, 32'h0000_0100},
        {1'b1, 32'h0000_0104}, {1'b1, 32'h0000_0100}, {1'b0, 32'h0000_0100},
        {1'b1, 32'h0000_0FFC}, {1'b1, 32'h0000_0FFC}, {1'b1, 32'h0000_0FFC},
        {1'b0, 32'h0000_0104}, {1'b1, 32'h0000_1100}, {1'b1, 32'h0000_0100},
        {1'b0, 32'h0000_0108}, {1'b0, 32'h0000_0108}, {1'b1, 32'h0000_0FFC},
        {1'b1, 32'h0000_0100}, {1'b0, 32'h0000_0104}, {1'b1, 32'h0000_0100}
    };

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        bit last_b2;
        m_clear();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state reads not-taken everywhere.
        probe(32'h0000_0000, "R1", "R1", "R1");
        probe(32'h0000_07FC, "R1", "R1", "R1");
        chk("R1", pred_taken, 1'b0);

        // Table-driven training sequence.
        foreach (VEC[i]) step(VEC[i][31:0], VEC[i][32], "R5");

        // Correlated pattern over four branches (one aliased pair).
        last_b2 = 1'b0;
        for (int k = 0; k < 400; k++) begin
            int b;
            bit tk;
            logic [31:0] pc;
            b = k % 4;
            case (b)
                0: begin pc = 32'h0000_1000; tk = ((k / 4) % 4) != 3; end
                1: begin pc = 32'h0000_1004; tk = 1'b1; end
                2: begin pc = 32'h0000_1008; tk = ((k / 4) % 2) == 1; last_b2 = tk; end
                default: begin pc = 32'h0000_2000; tk = last_b2; end
            endcase
            step(pc, tk, "R6");
        end

        // R2: address bits [11:2] alias; outside them, entries differ.
        probe(32'h0000_3000, "R2", "R4", "R5");
        probe(32'h0000_300C, "R2", "R4", "R5");

        // R3: saturate one history/counter pair with repeated taken.
        for (int k = 0; k < 24; k++) step(32'h0000_0500, 1'b1, "R3");
        probe(32'h0000_0500, "R3", "R4", "R5");
        chk("R3", pred_local, 1'b1);

        // R8: same-cycle predict and update; effect seen after the edge.
        @(negedge clk);
        pred_pc = 32'h0000_0700;
        #1;
        chk("R8", pred_local, m_local(32'h0000_0700));
        chk("R8", pred_taken, m_final(32'h0000_0700));
        upd_valid = 1'b1; upd_pc = 32'h0000_0700; upd_taken = 1'b0;
        upd_local = 1'b1; upd_global = 1'b0;
        #1;
        chk("R8", pred_global, m_global());
        @(posedge clk);
        m_update(32'h0000_0700, 1'b0, 1'b1, 1'b0);
        #1;
        chk("R8", pred_local,  m_local(32'h0000_0700));
        chk("R8", pred_global, m_global());
        chk("R8", pred_taken,  m_final(32'h0000_0700));
        @(negedge clk);
        upd_valid = 1'b0;

        // R7: context clear together with an update; clear wins.
        @(negedge clk);
        ctx_clear = 1'b1;
        upd_valid = 1'b1; upd_pc = 32'h0000_0500; upd_taken = 1'b1;
        upd_local = 1'b1; upd_global = 1'b0;
        @(posedge clk);
        m_clear();
        @(negedge clk);
        ctx_clear = 1'b0;
        upd_valid = 1'b0;
        probe(32'h0000_0500, "R7", "R7", "R7");
        chk("R7", pred_local, 1'b0);
        probe(32'h0000_1000, "R7", "R7", "R7");

        // R6: after clear, retrain and compare choice-driven result.
        for (int k = 0; k < 12; k++) step(32'h0000_0040, k[0], "R6");

        // R1: mid-run reset.
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        m_clear();
        @(negedge clk);
        rst_n = 1'b1;
        probe(32'h0000_0040, "R1", "R1", "R1");
        probe(32'h0000_0500, "R1", "R1", "R1");

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule